// File: doc/BRIEF.md
# Linear Access Split and Check Unit

This unit accepts one memory request described by a linear address and a byte length. It checks the request for address-form, privilege-half and alignment violations. If the request passes, it breaks the request into at most two descriptors, each confined to one 4096-byte page. A descriptor carries a linear address, a chunk length and the offset, within the request's data buffer, of the bytes that the chunk moves. A later translation stage consumes these descriptors. This unit does no translation, holds no TLB and makes no memory access.

The request is sampled in the cycle in which `req_valid` is high. One cycle later the result appears with a single-cycle `rsp_valid` strobe. When a check fails, the result holds a fault code and no descriptor. When several checks fail at once, only the highest-priority fault is reported. In 64-bit mode the address of the second page is checked again. In legacy mode that address is instead wrapped to 32 bits.

Top module: `lin_split_unit`

## Requirements
- R1: A request is user-mode exactly when `req_cpl` equals 3. Levels 0, 1 and 2 are all supervisor.
- R2: Canonical check on the first address. An address is canonical when bits 63 down to 47 are all equal. If the first address is not canonical, the result has fault code 1, `rsp_pages` = 0, and every address, length and offset output is 0. This check applies in both modes.
- R3: Half-separation check on the first address. It applies when `req_mode64` and `req_sep_en` are both 1. A user request faults with code 2 when address bit 63 is 1. A supervisor request faults with code 2 when address bit 63 is 0.
- R4: Alignment check. Fault code 3 is raised exactly when `req_ac_en` is 1, the request is user-mode, and (address bits 11:0 AND `req_align_mask`) is nonzero.
- R5: Single page. When (address bits 11:0) + length ≤ 4096, the result has `rsp_pages` = 1, `rsp_addr0` = the address, `rsp_len0` = the length, and `rsp_addr1`, `rsp_len1`, `rsp_off0` and `rsp_off1` all 0.
- R6: Page split. Otherwise the result has `rsp_pages` = 2, `rsp_len0` = 4096 − page offset, `rsp_len1` = length − `rsp_len0`, and `rsp_addr1` = address + `rsp_len0`.
- R7: Legacy wrap. When `req_mode64` = 0, `rsp_addr1` keeps only the low 32 bits of the sum, and its upper 32 bits are zero.
- R8: Second-address checks. In 64-bit mode a split request checks the second address as well. A non-canonical second address gives code 4. A half-separation violation on the second address (under the rule of R3) gives code 5.
- R9: Byte offsets. In little-endian order (`req_big_endian` = 0), `rsp_off0` = 0 and `rsp_off1` = `rsp_len0`. In big-endian order, `rsp_off0` = `rsp_len1` (that is, length − `rsp_len0`) and `rsp_off1` = 0.
- R10: Fault priority. The order is code 1, then 2, then 3, then 4, then 5. Only the first fault that applies is reported.
- R11: Timing. `rsp_valid` is high for exactly the one cycle after each cycle with `req_valid` high, and the fields come with it. `rsp_write` echoes `req_write`. After reset, `rsp_valid`, `rsp_pages` and `rsp_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 64 | Linear address of first byte |
| req_len | input | 7 | Byte length, 1 to 64 |
| req_cpl | input | 2 | Current privilege level |
| req_write | input | 1 | 1 = write, 0 = read |
| req_align_mask | input | 12 | Mask applied to the page offset for the alignment check |
| req_mode64 | input | 1 | 64-bit mode |
| req_sep_en | input | 1 | Enables the bit-63 half-separation check |
| req_ac_en | input | 1 | Enables the alignment check |
| req_big_endian | input | 1 | Byte order used for chunk offsets |
| rsp_valid | output | 1 | Result strobe |
| rsp_pages | output | 2 | Descriptor count: 0, 1 or 2 |
| rsp_addr0 | output | 64 | First chunk address |
| rsp_addr1 | output | 64 | Second chunk address |
| rsp_len0 | output | 7 | First chunk length |
| rsp_len1 | output | 7 | Second chunk length |
| rsp_off0 | output | 6 | Data buffer offset for the first chunk |
| rsp_off1 | output | 6 | Data buffer offset for the second chunk |
| rsp_fault | output | 3 | Fault code: 0 = none, 1 to 5 as in R2 to R8 |
| rsp_write | output | 1 | Echo of the request direction |

## Verification
Every result is registered once, so any fault in the split arithmetic or in the check logic appears in the strobe cycle of the request that causes it. Nothing is retained between requests, so the error is never deferred to a later request. A wrong page-crossing decision shows as a wrong `rsp_pages` value together with swapped or zero lengths. A wrong wrap or a missed second-page check shows in `rsp_addr1` or as a missing code 4 or 5. A broken priority encoder shows as a lower-priority fault code on requests that fail several checks at once.

// File: rtl/lin_split_pkg.sv
`timescale 1ns/1ps
package lin_split_pkg;

    localparam int ADDR_W      = 64;
    localparam int DEF_LIN_W   = 48;
    localparam int DEF_PG_BITS = 12;
    localparam int DEF_MAX_LEN = 64;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_CANON_A = 3'd1,
        FLT_SEP_A   = 3'd2,
        FLT_ALIGN   = 3'd3,
        FLT_CANON_B = 3'd4,
        FLT_SEP_B   = 3'd5
    } fault_e;

    typedef struct packed {
        logic canon_bad;
        logic sep_bad;
    } chk_res_t;

    // True when every bit from lin_w-1 up to the top matches.
    function automatic logic addr_is_canon(input logic [ADDR_W-1:0] a, input int lin_w);
        logic [ADDR_W-1:0] ext;
        ext = ADDR_W'($signed(a) >>> (lin_w - 1));
        return (ext == '0) || (ext == '1);
    endfunction

    // Upper half belongs to supervisor, lower half to user.
    function automatic logic half_violation(input logic [ADDR_W-1:0] a, input logic user);
        return a[ADDR_W-1] == user;
    endfunction

endpackage

// File: rtl/lin_addr_check.sv
`timescale 1ns/1ps
module lin_addr_check
    import lin_split_pkg::*;
#(
    parameter int LIN_W = DEF_LIN_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              user,
    input  logic              sep_on,
    output chk_res_t          res
);
    always_comb begin
        res.canon_bad = !addr_is_canon(addr, LIN_W);
        res.sep_bad   = sep_on && half_violation(addr, user);
    end
endmodule

// File: rtl/lin_page_split.sv
`timescale 1ns/1ps
module lin_page_split
    import lin_split_pkg::*;
#(
    parameter int PG_BITS = DEF_PG_BITS,
    parameter int LEN_W   = 7,
    parameter int OFF_W   = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic              mode64,
    input  logic              big_endian,
    output logic              crosses,
    output logic [ADDR_W-1:0] addr_b_raw,
    output logic [ADDR_W-1:0] addr_b,
    output logic [LEN_W-1:0]  len_a,
    output logic [LEN_W-1:0]  len_b,
    output logic [OFF_W-1:0]  off_a,
    output logic [OFF_W-1:0]  off_b
);
    localparam logic [PG_BITS:0] PAGE_SIZE = (PG_BITS+1)'(1) << PG_BITS;

    logic [PG_BITS-1:0] pg_off;
    logic [PG_BITS:0]   end_pos;
    logic [PG_BITS:0]   room;

    always_comb begin
        pg_off  = addr[PG_BITS-1:0];
        end_pos = {1'b0, pg_off} + (PG_BITS+1)'(len);
        room    = PAGE_SIZE - {1'b0, pg_off};
        crosses = end_pos > PAGE_SIZE;

        len_a = crosses ? room[LEN_W-1:0] : len;
        len_b = crosses ? (len - len_a) : '0;

        addr_b_raw = addr + ADDR_W'(len_a);
        if (!crosses)
            addr_b = '0;
        else if (mode64)
            addr_b = addr_b_raw;
        else
            addr_b = {32'b0, addr_b_raw[31:0]};

        off_a = (crosses && big_endian)  ? len_b[OFF_W-1:0] : '0;
        off_b = (crosses && !big_endian) ? len_a[OFF_W-1:0] : '0;
    end
endmodule

// File: rtl/lin_fault_sel.sv
`timescale 1ns/1ps
module lin_fault_sel
    import lin_split_pkg::*;
(
    input  chk_res_t chk_a,
    input  chk_res_t chk_b,
    input  logic     align_hit,
    input  logic     second_on,
    output fault_e   fault
);
    always_comb begin
        if (chk_a.canon_bad)
            fault = FLT_CANON_A;
        else if (chk_a.sep_bad)
            fault = FLT_SEP_A;
        else if (align_hit)
            fault = FLT_ALIGN;
        else if (second_on && chk_b.canon_bad)
            fault = FLT_CANON_B;
        else if (second_on && chk_b.sep_bad)
            fault = FLT_SEP_B;
        else
            fault = FLT_NONE;
    end
endmodule

// File: rtl/lin_split_unit.sv
`timescale 1ns/1ps
module lin_split_unit
    import lin_split_pkg::*;
#(
    parameter int LIN_W   = DEF_LIN_W,
    parameter int PG_BITS = DEF_PG_BITS,
    parameter int MAX_LEN = DEF_MAX_LEN,
    localparam int LEN_W  = $clog2(MAX_LEN + 1),
    localparam int OFF_W  = $clog2(MAX_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [1:0]        req_cpl,
    input  logic              req_write,
    input  logic [PG_BITS-1:0] req_align_mask,
    input  logic              req_mode64,
    input  logic              req_sep_en,
    input  logic              req_ac_en,
    input  logic              req_big_endian,
    output logic              rsp_valid,
    output logic [1:0]        rsp_pages,
    output logic [ADDR_W-1:0] rsp_addr0,
    output logic [ADDR_W-1:0] rsp_addr1,
    output logic [LEN_W-1:0]  rsp_len0,
    output logic [LEN_W-1:0]  rsp_len1,
    output logic [OFF_W-1:0]  rsp_off0,
    output logic [OFF_W-1:0]  rsp_off1,
    output logic [2:0]        rsp_fault,
    output logic              rsp_write
);
    logic              is_user;
    logic              sep_on;
    logic              align_hit;
    logic              crosses;
    logic [ADDR_W-1:0] addr_b_raw;
    logic [ADDR_W-1:0] addr_b;
    logic [LEN_W-1:0]  len_a, len_b;
    logic [OFF_W-1:0]  off_a, off_b;
    fault_e            fault;
    chk_res_t          chk [2];
    logic [ADDR_W-1:0] chk_addr [2];

    always_comb begin
        is_user     = (req_cpl == 2'd3);
        sep_on      = req_mode64 && req_sep_en;
        align_hit   = req_ac_en && is_user && |(req_addr[PG_BITS-1:0] & req_align_mask);
        chk_addr[0] = req_addr;
        chk_addr[1] = addr_b_raw;
    end

    lin_page_split #(
        .PG_BITS (PG_BITS),
        .LEN_W   (LEN_W),
        .OFF_W   (OFF_W)
    ) split_i (
        .addr       (req_addr),
        .len        (req_len),
        .mode64     (req_mode64),
        .big_endian (req_big_endian),
        .crosses    (crosses),
        .addr_b_raw (addr_b_raw),
        .addr_b     (addr_b),
        .len_a      (len_a),
        .len_b      (len_b),
        .off_a      (off_a),
        .off_b      (off_b)
    );

    for (genvar gi = 0; gi < 2; gi++) begin : g_chk
        lin_addr_check #(.LIN_W(LIN_W)) chk_i (
            .addr   (chk_addr[gi]),
            .user   (is_user),
            .sep_on (sep_on),
            .res    (chk[gi])
        );
    end

    lin_fault_sel fsel_i (
        .chk_a     (chk[0]),
        .chk_b     (chk[1]),
        .align_hit (align_hit),
        .second_on (crosses && req_mode64),
        .fault     (fault)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_pages <= '0;
            rsp_addr0 <= '0;
            rsp_addr1 <= '0;
            rsp_len0  <= '0;
            rsp_len1  <= '0;
            rsp_off0  <= '0;
            rsp_off1  <= '0;
            rsp_fault <= FLT_NONE;
            rsp_write <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_write <= req_write;
                rsp_fault <= fault;
                if (fault != FLT_NONE) begin
                    rsp_pages <= '0;
                    rsp_addr0 <= '0;
                    rsp_addr1 <= '0;
                    rsp_len0  <= '0;
                    rsp_len1  <= '0;
                    rsp_off0  <= '0;
                    rsp_off1  <= '0;
                end else begin
                    rsp_pages <= crosses ? 2'd2 : 2'd1;
                    rsp_addr0 <= req_addr;
                    rsp_addr1 <= addr_b;
                    rsp_len0  <= len_a;
                    rsp_len1  <= len_b;
                    rsp_off0  <= off_a;
                    rsp_off1  <= off_b;
                end
            end
        end
    end
endmodule

// File: rtl/lin_split_chk.sv
`timescale 1ns/1ps
module lin_split_chk #(
    parameter int LEN_W = 7,
    parameter int OFF_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [LEN_W-1:0] req_len,
    input logic [1:0]       req_cpl,
    input logic             req_mode64,
    input logic             req_sep_en,
    input logic             req_big_endian,
    input logic             rsp_valid,
    input logic [1:0]       rsp_pages,
    input logic [63:0]      rsp_addr0,
    input logic [63:0]      rsp_addr1,
    input logic [LEN_W-1:0] rsp_len0,
    input logic [LEN_W-1:0] rsp_len1,
    input logic [OFF_W-1:0] rsp_off0,
    input logic [OFF_W-1:0] rsp_off1,
    input logic [2:0]       rsp_fault
);
    assert_fault_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 3'd0) |-> (rsp_pages == 2'd0 && rsp_len0 == '0 && rsp_addr0 == '0));

    assert_half_sep_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_pages != 2'd0 && $past(req_mode64 && req_sep_en))
        |-> (rsp_addr0[63] != ($past(req_cpl) == 2'd3)));

    assert_single_len_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_pages == 2'd1) |-> (rsp_len0 == $past(req_len) && rsp_len1 == '0));

    assert_split_sum_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_pages == 2'd2)
        |-> (({1'b0, rsp_len0} + {1'b0, rsp_len1}) == {1'b0, $past(req_len)}));

    assert_legacy_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_pages == 2'd2 && !$past(req_mode64)) |-> (rsp_addr1[63:32] == 32'd0));

    assert_be_offsets_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_pages == 2'd2 && $past(req_big_endian))
        |-> (rsp_off1 == '0 && rsp_off0 == rsp_len1[OFF_W-1:0]));

    assert_strobe_on_R11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_strobe_off_R11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
endmodule

bind lin_split_unit lin_split_chk #(.LEN_W(LEN_W), .OFF_W(OFF_W)) chk_bind_i (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_len        (req_len),
    .req_cpl        (req_cpl),
    .req_mode64     (req_mode64),
    .req_sep_en     (req_sep_en),
    .req_big_endian (req_big_endian),
    .rsp_valid      (rsp_valid),
    .rsp_pages      (rsp_pages),
    .rsp_addr0      (rsp_addr0),
    .rsp_addr1      (rsp_addr1),
    .rsp_len0       (rsp_len0),
    .rsp_len1       (rsp_len1),
    .rsp_off0       (rsp_off0),
    .rsp_off1       (rsp_off1),
    .rsp_fault      (rsp_fault)
);

// File: tb/lin_split_unit_tb_top.sv
`timescale 1ns/1ps
module lin_split_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic [6:0]  req_len = 7'd1;
    logic [1:0]  req_cpl = '0;
    logic        req_write = 1'b0;
    logic [11:0] req_align_mask = '0;
    logic        req_mode64 = 1'b1;
    logic        req_sep_en = 1'b0;
    logic        req_ac_en = 1'b0;
    logic        req_big_endian = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_pages;
    logic [63:0] rsp_addr0, rsp_addr1;
    logic [6:0]  rsp_len0, rsp_len1;
    logic [5:0]  rsp_off0, rsp_off1;
    logic [2:0]  rsp_fault;
    logic        rsp_write;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    lin_split_unit dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .req_cpl(req_cpl), .req_write(req_write),
        .req_align_mask(req_align_mask), .req_mode64(req_mode64),
        .req_sep_en(req_sep_en), .req_ac_en(req_ac_en),
        .req_big_endian(req_big_endian), .rsp_valid(rsp_valid),
        .rsp_pages(rsp_pages), .rsp_addr0(rsp_addr0), .rsp_addr1(rsp_addr1),
        .rsp_len0(rsp_len0), .rsp_len1(rsp_len1), .rsp_off0(rsp_off0),
        .rsp_off1(rsp_off1), .rsp_fault(rsp_fault), .rsp_write(rsp_write)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic canon(input logic [63:0] a);
        return (a[63:47] == 17'h00000) || (a[63:47] == 17'h1FFFF);
    endfunction

    // Expected result from the requirements.
    logic [2:0]  e_fault;
    logic [1:0]  e_pages;
    logic [63:0] e_a0, e_a1;
    int          e_l0, e_l1, e_o0, e_o1;

    task automatic model();
        logic        user;
        int          off;
        logic [63:0] a2;
        user = (req_cpl == 2'd3);             // R1
        off  = int'(req_addr[11:0]);
        e_fault = 0; e_pages = 0; e_a0 = 0; e_a1 = 0;
        e_l0 = 0; e_l1 = 0; e_o0 = 0; e_o1 = 0;
        if (!canon(req_addr)) e_fault = 1;
        else if (req_mode64 && req_sep_en && req_addr[63] == user) e_fault = 2;
        else if (req_ac_en && user && (req_addr[11:0] & req_align_mask) != 0) e_fault = 3;
        else if (off + int'(req_len) <= 4096) begin
            e_pages = 1; e_a0 = req_addr; e_l0 = int'(req_len);
        end else begin
            e_pages = 2; e_a0 = req_addr;
            e_l0 = 4096 - off;
            e_l1 = int'(req_len) - e_l0;
            a2 = req_addr + 64'(e_l0);
            if (!req_mode64) a2 = a2 & 64'h0000_0000_FFFF_FFFF;
            else if (!canon(a2)) e_fault = 4;
            else if (req_sep_en && a2[63] == user) e_fault = 5;
            e_a1 = a2;
            if (req_big_endian) begin e_o0 = e_l1; e_o1 = 0; end
            else begin e_o0 = 0; e_o1 = e_l0; end
            if (e_fault != 0) begin
                e_pages = 0; e_a0 = 0; e_a1 = 0; e_l0 = 0; e_l1 = 0; e_o0 = 0; e_o1 = 0;
            end
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge.
    task automatic send(input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        model();
        @(negedge clk);
        req_valid = 1'b0;
        n_checks++;
        if (rsp_valid !== 1'b1 || rsp_fault !== e_fault || rsp_pages !== e_pages ||
            rsp_addr0 !== e_a0 || rsp_addr1 !== e_a1 ||
            rsp_len0 !== 7'(e_l0) || rsp_len1 !== 7'(e_l1) ||
            rsp_off0 !== 6'(e_o0) || rsp_off1 !== 6'(e_o1)) begin
            n_fail++;
            $display("FAIL %s addr=%h len=%0d actual v=%b f=%0d p=%0d a0=%h a1=%h l=%0d/%0d o=%0d/%0d expected f=%0d p=%0d a0=%h a1=%h l=%0d/%0d o=%0d/%0d",
                     tag, req_addr, req_len, rsp_valid, rsp_fault, rsp_pages, rsp_addr0, rsp_addr1,
                     rsp_len0, rsp_len1, rsp_off0, rsp_off1, e_fault, e_pages, e_a0, e_a1,
                     e_l0, e_l1, e_o0, e_o1);
        end
    endtask

    task automatic set_req(input logic [63:0] a, input int len, input logic [1:0] cpl,
                           input logic m64, input logic sep, input logic ac,
                           input logic [11:0] mask, input logic be);
        req_addr = a; req_len = 7'(len); req_cpl = cpl; req_mode64 = m64;
        req_sep_en = sep; req_ac_en = ac; req_align_mask = mask; req_big_endian = be;
    endtask

    initial begin
        #1ms;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 reset valid", 64'(rsp_valid), 64'd0);
        check("R11 reset pages", 64'(rsp_pages), 64'd0);
        check("R11 reset fault", 64'(rsp_fault), 64'd0);

        // R5 R6 R9 sweep in 64-bit mode, both byte orders
        for (int be = 0; be < 2; be++) begin
            for (int oi = 0; oi < 69; oi++) begin
                int off;
                off = (oi < 4) ? oi * 37 : 4031 + (oi - 4);
                for (int len = 1; len <= 64; len++) begin
                    set_req(64'h0000_1234_5678_0000 + 64'(off), len, 2'd0, 1'b1, 1'b0, 1'b0, 12'h0, be[0]);
                    send((off + len <= 4096) ? "R5 single page" : "R6 R9 split");
                end
            end
        end

        // R7 legacy wrap sweep near the 4 GiB top
        for (int off = 4032; off < 4096; off += 3) begin
            for (int len = 60; len <= 64; len++) begin
                set_req(64'h0000_0000_FFFF_F000 + 64'(off), len, 2'd3, 1'b0, 1'b1, 1'b0, 12'h0, 1'b0);
                send("R7 legacy wrap");
            end
        end
        set_req(64'h0000_0000_FFFF_FFF8, 16, 2'd0, 1'b0, 1'b0, 1'b0, 12'h0, 1'b0);
        send("R7 wrap to zero");
        check("R7 second addr", rsp_addr1, 64'h0);

        // R2 canonical
        set_req(64'h0000_8000_0000_0000, 4, 2'd0, 1'b1, 1'b0, 1'b0, 12'h0, 1'b0);
        send("R2 noncanonical");
        check("R2 code", 64'(rsp_fault), 64'd1);
        set_req(64'hFFFF_8000_0000_0000, 4, 2'd0, 1'b1, 1'b0, 1'b0, 12'h0, 1'b0);
        send("R2 canonical high");
        set_req(64'h0001_0000_0000_0000, 4, 2'd0, 1'b0, 1'b0, 1'b0, 12'h0, 1'b0);
        send("R2 legacy noncanonical");

        // R3 R1 separation for every privilege level and both halves
        for (int cpl = 0; cpl < 4; cpl++) begin
            set_req(64'hFFFF_FFFF_FFFF_F000, 8, 2'(cpl), 1'b1, 1'b1, 1'b0, 12'h0, 1'b0);
            send("R3 R1 upper half");
            set_req(64'h0000_0000_0000_1000, 8, 2'(cpl), 1'b1, 1'b1, 1'b0, 12'h0, 1'b0);
            send("R3 R1 lower half");
            set_req(64'h0000_0000_0000_1000, 8, 2'(cpl), 1'b1, 1'b0, 1'b0, 12'h0, 1'b0);
            send("R3 disabled");
        end
        set_req(64'h0000_0000_0000_1000, 8, 2'd1, 1'b1, 1'b1, 1'b0, 12'h0, 1'b0);
        send("R1 level 1 supervisor");
        check("R1 level 1 code", 64'(rsp_fault), 64'd2);

        // R4 alignment: mask, privilege and enable combinations
        for (int cpl = 0; cpl < 4; cpl++) begin
            for (int m = 0; m < 8; m++) begin
                for (int ac = 0; ac < 2; ac++) begin
                    set_req(64'h0000_0000_0040_0006, 4, 2'(cpl), 1'b1, 1'b0, ac[0], 12'(m), 1'b0);
                    send("R4 alignment");
                end
            end
        end
        set_req(64'h0000_0000_0040_0002, 4, 2'd3, 1'b1, 1'b0, 1'b1, 12'h3, 1'b0);
        send("R4 user misaligned");
        check("R4 code", 64'(rsp_fault), 64'd3);

        // R8 second-address checks
        set_req(64'h0000_7FFF_FFFF_FFFC, 8, 2'd0, 1'b1, 1'b0, 1'b0, 12'h0, 1'b0);
        send("R8 second noncanonical");
        check("R8 code 4", 64'(rsp_fault), 64'd4);
        set_req(64'hFFFF_FFFF_FFFF_FFFC, 8, 2'd0, 1'b1, 1'b1, 1'b0, 12'h0, 1'b0);
        send("R8 second separation");
        check("R8 code 5", 64'(rsp_fault), 64'd5);
        set_req(64'hFFFF_FFFF_FFFF_FFFC, 8, 2'd0, 1'b1, 1'b0, 1'b0, 12'h0, 1'b1);
        send("R8 second ok no sep");
        set_req(64'h0000_7FFF_FFFF_FFFC, 8, 2'd0, 1'b0, 1'b0, 1'b0, 12'h0, 1'b0);
        send("R8 legacy skips second check");

        // R10 priority with several faults at once
        set_req(64'h8000_0000_0000_0001, 8, 2'd3, 1'b1, 1'b1, 1'b1, 12'h1, 1'b0);
        send("R10 canon over rest");
        check("R10 code 1", 64'(rsp_fault), 64'd1);
        set_req(64'hFFFF_FFFF_FFFF_FFFD, 8, 2'd3, 1'b1, 1'b1, 1'b1, 12'h1, 1'b0);
        send("R10 sep over align");
        check("R10 code 2", 64'(rsp_fault), 64'd2);
        set_req(64'h0000_7FFF_FFFF_FFFD, 8, 2'd3, 1'b1, 1'b1, 1'b1, 12'h1, 1'b0);
        send("R10 align over second");
        check("R10 code 3", 64'(rsp_fault), 64'd3);

        // R11 strobe length and write echo
        req_write = 1'b1;
        set_req(64'h0000_0000_0000_2000, 4, 2'd0, 1'b1, 1'b0, 1'b0, 12'h0, 1'b0);
        send("R11 write request");
        check("R11 write echo", 64'(rsp_write), 64'd1);
        @(negedge clk);
        check("R11 strobe one cycle", 64'(rsp_valid), 64'd0);
        req_write = 1'b0;
        send("R11 read request");
        check("R11 read echo", 64'(rsp_write), 64'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule